// File: doc/BRIEF.md
# Processor Address Decoder With Mirroring

This block sits between a small 8-bit processor's bus and the units on its 16-bit address map. It takes an address, write data and read/write strobes. It drives one chip select per target, a register index for each target and a forwarded copy of the write data and write strobe. It also returns read data. The map has a 2 KB work RAM that repeats four times in the lowest 8 KB and eight video registers that repeat across the next 8 KB. It also has a small window of audio and IO registers, two controller ports, an unmapped hole that reads as zero, and a cartridge window over the top 40 KB.

Read data is combinational. It comes from an AND-OR multiplexer that picks the source the decode chooses. A read that hits nothing returns zero. Two side effects of register accesses bear on interrupt timing. A video status read made while the dot counter is 2 or 3 cancels the non-maskable interrupt. A write to the video control register can cancel that interrupt or ask for a delayed one. The block keeps its own copy of the control register's interrupt-enable bit, so it can see when that bit turns on. Both side effects come out as registered one-cycle pulses.

Top module: `addr_decoder`

## Requirements
- R1: An access below 0x2000 raises `ram_cs` and drives `ram_addr` with address bits 10..0, so 0x0800, 0x1000 and 0x1800 alias 0x0000. A read there returns `ram_rdata`.
- R2: An access in 0x2000–0x3FFF drives `vid_reg` with address bits 2..0. It raises `vid_cs` for every read and for writes to every index except 2. A write to index 2 raises no select.
- R3: Video reads at indices 2, 4 and 7 return `vid_rdata`. Reads at the other five indices return 0x00.
- R4: A read of video index 2 while `vid_dot` is 2 or 3 makes `nmi_suppress` high for exactly the cycle after that clock edge. At any other dot value, or at any other index, it has no such effect.
- R5: A read of 0x4015 raises `apu_cs` and returns `apu_status`. Reads of 0x4000–0x401F other than 0x4015, 0x4016 and 0x4017 return 0x00 and raise no select.
- R6: A read of 0x4016 or 0x4017 returns port 1 or port 2 data and raises `pad_rd` bit 0 or bit 1. This happens only when that port's `pad_present` bit is 1. Otherwise the read returns 0x00 and raises no strobe.
- R7: A write to 0x4000–0x4013, 0x4015 or 0x4017 raises `apu_cs`, and `apu_reg` carries address bits 4..0. A write to 0x4016 raises `pad_wr` for both ports. A write to 0x4014 raises `dma_start`. Write data leaves on `fwd_wdata`.
- R8: Addresses 0x4018–0x5FFF read as 0x00, and writes to them raise no select or strobe.
- R9: An access at 0x6000 or above raises `cart_cs`. A read there returns `cart_rdata`.
- R10: A write to video index 0 with data bit 7 clear, made while `late_flag` is high, makes `nmi_suppress` high in the cycle after the edge.
- R11: A write to video index 0 with data bit 7 set makes `nmi_delayed` high in the cycle after the edge. This happens only while `vid_vblank` is high and the stored enable bit is 0. The stored bit is 0 after reset and takes data bit 7 at each such write.
- R12: After reset both interrupt outputs are low. With `bus_rd` low, `bus_rdata` is 0x00. With both strobes low, no select is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data returned to the processor |
| fwd_wdata | output | 8 | Write data forwarded to targets |
| fwd_wr | output | 1 | Write strobe forwarded to targets |
| ram_cs | output | 1 | Work RAM select |
| ram_addr | output | 11 | Work RAM address after mirroring |
| ram_rdata | input | 8 | Work RAM read data |
| vid_cs | output | 1 | Video register select |
| vid_reg | output | 3 | Video register index |
| vid_rdata | input | 8 | Video register read data |
| vid_dot | input | 9 | Video dot counter |
| vid_vblank | input | 1 | Video vertical blank flag |
| late_flag | input | 1 | Scheduler flag: the interrupt was raised late in the last step |
| apu_cs | output | 1 | Audio/IO register select |
| apu_reg | output | 5 | Audio/IO register index |
| apu_status | input | 8 | Audio status read data |
| dma_start | output | 1 | Sprite DMA start strobe |
| pad_wr | output | 1 | Write strobe to both controller ports |
| pad_rd | output | 2 | Read strobes, bit 0 port 1, bit 1 port 2 |
| pad_present | input | 2 | Per-port present flags |
| pad1_rdata | input | 8 | Port 1 read data |
| pad2_rdata | input | 8 | Port 2 read data |
| cart_cs | output | 1 | Cartridge select |
| cart_rdata | input | 8 | Cartridge read data |
| nmi_suppress | output | 1 | Pulse: cancel the pending NMI |
| nmi_delayed | output | 1 | Pulse: request a delayed NMI |

## Verification
Each test source drives its own read value, so a wrong multiplexer choice shows up as a wrong byte. One read sweep covers both edges of every region, the mirrored aliases and every special IO address, with the select vector compared at each step. Directed accesses then check the mirrored index lines and the writes that must raise nothing: to video index 2, to the 0x4018 gap and to the hole. A missing controller port is also tried. The interrupt pulses are tried with dot values just inside and just outside the 2–3 window. Control writes cover enable rising with vertical blank, enable already on, enable rising outside vertical blank, and clearing with and without the late flag. These cases separate an edge detect from a plain level check.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int unsigned ADDR_W = 16;

  localparam logic [ADDR_W-1:0] VID_BASE  = 16'h2000;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'h4000;
  localparam logic [ADDR_W-1:0] HOLE_BASE = 16'h4020;
  localparam logic [ADDR_W-1:0] CART_BASE = 16'h6000;

  localparam logic [4:0] IO_APU_LAST = 5'h13;
  localparam logic [4:0] IO_DMA      = 5'h14;
  localparam logic [4:0] IO_STATUS   = 5'h15;
  localparam logic [4:0] IO_PAD1     = 5'h16;
  localparam logic [4:0] IO_FRAME    = 5'h17;

  localparam logic [2:0] VREG_CTRL   = 3'd0;
  localparam logic [2:0] VREG_STATUS = 3'd2;
  localparam logic [2:0] VREG_SPRITE = 3'd4;
  localparam logic [2:0] VREG_DATA   = 3'd7;

  localparam int unsigned NSRC = 6;

  typedef enum logic [2:0] {
    RG_RAM, RG_VID, RG_IO, RG_HOLE, RG_CART
  } region_e;
endpackage

// File: rtl/adec_region.sv
module adec_region
  import adec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    if (addr < VID_BASE)       region = RG_RAM;
    else if (addr < IO_BASE)   region = RG_VID;
    else if (addr < HOLE_BASE) region = RG_IO;
    else if (addr < CART_BASE) region = RG_HOLE;
    else                       region = RG_CART;
  end
endmodule

// File: rtl/adec_select.sv
module adec_select
  import adec_pkg::*;
#(
  parameter int unsigned NPAD = 2
) (
  input  region_e         region,
  input  logic [4:0]      low_addr,
  input  logic            rd,
  input  logic            wr,
  input  logic [NPAD-1:0] pad_present,
  output logic            ram_cs,
  output logic            vid_cs,
  output logic            apu_cs,
  output logic            cart_cs,
  output logic            dma_start,
  output logic            pad_wr,
  output logic [NPAD-1:0] pad_rd,
  output logic            status_rd,
  output logic            ctrl_wr,
  output logic [NSRC-1:0] src_hit
);
  logic       access;
  logic       in_io;
  logic       in_vid;
  logic [2:0] vreg;
  logic       vid_has_data;
  logic       apu_wr_ok;

  assign access = rd | wr;
  assign in_io  = (region == RG_IO);
  assign in_vid = (region == RG_VID);
  assign vreg   = low_addr[2:0];

  assign vid_has_data = (vreg == VREG_STATUS) || (vreg == VREG_SPRITE) ||
                        (vreg == VREG_DATA);
  assign apu_wr_ok    = (low_addr <= IO_APU_LAST) || (low_addr == IO_STATUS) ||
                        (low_addr == IO_FRAME);

  assign ram_cs    = (region == RG_RAM) && access;
  assign vid_cs    = in_vid && (rd || (wr && (vreg != VREG_STATUS)));
  assign apu_cs    = in_io && ((rd && (low_addr == IO_STATUS)) || (wr && apu_wr_ok));
  assign cart_cs   = (region == RG_CART) && access;
  assign dma_start = in_io && wr && (low_addr == IO_DMA);
  assign pad_wr    = in_io && wr && (low_addr == IO_PAD1);
  assign status_rd = in_vid && rd && (vreg == VREG_STATUS);
  assign ctrl_wr   = in_vid && wr && (vreg == VREG_CTRL);

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    assign pad_rd[p] = in_io && rd && pad_present[p] &&
                       (low_addr == IO_PAD1 + 5'(p));
  end

  assign src_hit[0] = ram_cs && rd;
  assign src_hit[1] = in_vid && rd && vid_has_data;
  assign src_hit[2] = apu_cs && rd;
  assign src_hit[3] = pad_rd[0];
  assign src_hit[4] = pad_rd[1];
  assign src_hit[5] = cart_cs && rd;
endmodule

// File: rtl/adec_rdmux.sv
module adec_rdmux #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      hit,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]      rdata
);
  logic [N:0][W-1:0] chain;

  assign chain[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign chain[i+1] = chain[i] | ({W{hit[i]}} & src[i]);
  end
  assign rdata = chain[N];

  // R12: no two sources ever drive the bus together
  p_single_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/adec_nmi_fx.sv
module adec_nmi_fx #(
  parameter int unsigned DOT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_rd,
  input  logic             ctrl_wr,
  input  logic             en_bit,
  input  logic [DOT_W-1:0] dot,
  input  logic             vblank,
  input  logic             late,
  output logic             suppress,
  output logic             delayed
);
  localparam logic [DOT_W-1:0] RACE_LO = DOT_W'(2);
  localparam logic [DOT_W-1:0] RACE_HI = DOT_W'(3);

  logic en_q, en_d;
  logic sup_q, sup_d;
  logic dly_q, dly_d;
  logic in_race;

  assign in_race = (dot == RACE_LO) || (dot == RACE_HI);

  always_comb begin
    en_d  = en_bit;
    sup_d = (status_rd && in_race) || (ctrl_wr && !en_bit && late);
    dly_d = ctrl_wr && en_bit && !en_q && vblank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sup_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= en_d;
      sup_q <= sup_d;
      dly_q <= dly_d;
    end
  end

  assign suppress = sup_q;
  assign delayed  = dly_q;

  // R4 / R10: a cancel pulse follows a status read or a control write
  p_sup_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sup_q |-> $past(status_rd || ctrl_wr));
  // R11: a delayed request needs vertical blank in the cycle it was raised
  p_dly_vblank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q |-> $past(vblank && ctrl_wr));
  // R11: no request while the enable was already on
  p_dly_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && en_q) |=> !dly_q);
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
  import adec_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAM_AW = 11,
  parameter int unsigned DOT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              fwd_wr,
  output logic              ram_cs,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              vid_cs,
  output logic [2:0]        vid_reg,
  input  logic [DATA_W-1:0] vid_rdata,
  input  logic [DOT_W-1:0]  vid_dot,
  input  logic              vid_vblank,
  input  logic              late_flag,
  output logic              apu_cs,
  output logic [4:0]        apu_reg,
  input  logic [DATA_W-1:0] apu_status,
  output logic              dma_start,
  output logic              pad_wr,
  output logic [1:0]        pad_rd,
  input  logic [1:0]        pad_present,
  input  logic [DATA_W-1:0] pad1_rdata,
  input  logic [DATA_W-1:0] pad2_rdata,
  output logic              cart_cs,
  input  logic [DATA_W-1:0] cart_rdata,
  output logic              nmi_suppress,
  output logic              nmi_delayed
);
  localparam int unsigned EN_BIT = DATA_W - 1;

  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  region_e              region;
  logic                 status_rd;
  logic                 ctrl_wr;
  logic [NSRC-1:0]      src_hit;
  logic [NSRC-1:0][DATA_W-1:0] src_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign fwd_wdata = bus_wdata;
  assign fwd_wr    = bus_wr;
  assign ram_addr  = bus_addr[RAM_AW-1:0];
  assign vid_reg   = bus_addr[2:0];
  assign apu_reg   = bus_addr[4:0];

  adec_region u_region (
    .addr   (bus_addr),
    .region (region)
  );

  adec_select #(.NPAD(2)) u_sel (
    .region      (region),
    .low_addr    (bus_addr[4:0]),
    .rd          (bus_rd),
    .wr          (bus_wr),
    .pad_present (pad_present),
    .ram_cs      (ram_cs),
    .vid_cs      (vid_cs),
    .apu_cs      (apu_cs),
    .cart_cs     (cart_cs),
    .dma_start   (dma_start),
    .pad_wr      (pad_wr),
    .pad_rd      (pad_rd),
    .status_rd   (status_rd),
    .ctrl_wr     (ctrl_wr),
    .src_hit     (src_hit)
  );

  assign src_data = {cart_rdata, pad2_rdata, pad1_rdata, apu_status, vid_rdata, ram_rdata};

  adec_rdmux #(.N(NSRC), .W(DATA_W)) u_mux (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hit   (src_hit),
    .src   (src_data),
    .rdata (bus_rdata)
  );

  adec_nmi_fx #(.DOT_W(DOT_W)) u_fx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .status_rd (status_rd),
    .ctrl_wr   (ctrl_wr),
    .en_bit    (bus_wdata[EN_BIT]),
    .dot       (vid_dot),
    .vblank    (vid_vblank),
    .late      (late_flag),
    .suppress  (nmi_suppress),
    .delayed   (nmi_delayed)
  );

  // R8: the hole always reads as zero
  p_hole_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr >= HOLE_BASE && bus_addr < CART_BASE) |-> (bus_rdata == '0));
  // R12: nothing reaches the bus without a read strobe
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |-> (bus_rdata == '0));
  // R7: at most one target is selected at a time
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ram_cs, vid_cs, apu_cs, cart_cs, dma_start, pad_wr, pad_rd}));
  // R12: no select without a strobe
  p_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_rd || bus_wr) |-> !(ram_cs || vid_cs || apu_cs || cart_cs || pad_wr || dma_start));
endmodule

// File: tb/addr_decoder_tb.sv
module addr_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_rdata, fwd_wdata;
  logic        fwd_wr, ram_cs, vid_cs, apu_cs, cart_cs, dma_start, pad_wr;
  logic [10:0] ram_addr;
  logic [2:0]  vid_reg;
  logic [4:0]  apu_reg;
  logic [1:0]  pad_rd, pad_present;
  logic [8:0]  vid_dot;
  logic        vid_vblank, late_flag, nmi_suppress, nmi_delayed;
  logic [7:0]  ram_rdata, vid_rdata, apu_status, pad1_rdata, pad2_rdata, cart_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .fwd_wdata(fwd_wdata), .fwd_wr(fwd_wr), .ram_cs(ram_cs), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .vid_cs(vid_cs), .vid_reg(vid_reg), .vid_rdata(vid_rdata),
    .vid_dot(vid_dot), .vid_vblank(vid_vblank), .late_flag(late_flag),
    .apu_cs(apu_cs), .apu_reg(apu_reg), .apu_status(apu_status),
    .dma_start(dma_start), .pad_wr(pad_wr), .pad_rd(pad_rd),
    .pad_present(pad_present), .pad1_rdata(pad1_rdata), .pad2_rdata(pad2_rdata),
    .cart_cs(cart_cs), .cart_rdata(cart_rdata),
    .nmi_suppress(nmi_suppress), .nmi_delayed(nmi_delayed)
  );

  // select vector: {ram, vid, apu, cart, pad_rd[0], pad_rd[1]}
  wire [5:0] sel = {ram_cs, vid_cs, apu_cs, cart_cs, pad_rd[0], pad_rd[1]};

  // {address, expected read data, expected select vector}
  localparam logic [29:0] RD_VEC [NVEC] = '{
    {16'h0000, 8'hA1, 6'h20},  // R1
    {16'h1FFF, 8'hA1, 6'h20},  // R1 top mirror
    {16'h2002, 8'hB2, 6'h10},  // R3
    {16'h2004, 8'hB2, 6'h10},  // R3
    {16'h3FFF, 8'hB2, 6'h10},  // R3 index 7 mirror
    {16'h2000, 8'h00, 6'h10},  // R3 index 0 zero
    {16'h2009, 8'h00, 6'h10},  // R3 index 1 mirror zero
    {16'h4015, 8'hC3, 6'h08},  // R5
    {16'h4016, 8'h41, 6'h02},  // R6
    {16'h4017, 8'h42, 6'h01},  // R6
    {16'h4000, 8'h00, 6'h00},  // R5
    {16'h4014, 8'h00, 6'h00},  // R5
    {16'h401F, 8'h00, 6'h00},  // R8
    {16'h4020, 8'h00, 6'h00},  // R8
    {16'h5FFF, 8'h00, 6'h00},  // R8
    {16'h6000, 8'hD4, 6'h04},  // R9
    {16'hFFFF, 8'hD4, 6'h04}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 0; bus_wr = 0;
    ram_rdata = 8'hA1; vid_rdata = 8'hB2; apu_status = 8'hC3;
    pad1_rdata = 8'h41; pad2_rdata = 8'h42; cart_rdata = 8'hD4;
    pad_present = 2'b11; vid_dot = 9'd100; vid_vblank = 0; late_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;

    chk("R12 reset suppress", nmi_suppress, 0);
    chk("R12 reset delayed", nmi_delayed, 0);
    chk("R12 idle rdata", bus_rdata, 0);
    chk("R12 idle selects", {sel, pad_wr, dma_start}, 0);

    for (int i = 0; i < NVEC; i++) begin
      drive(RD_VEC[i][29:14], 1, 0, 8'h00);
      chk($sformatf("R1/R3/R5/R6/R8/R9 rdata @%h", RD_VEC[i][29:14]), bus_rdata, RD_VEC[i][13:6]);
      chk($sformatf("R1/R2/R5/R6/R8/R9 sel @%h", RD_VEC[i][29:14]), sel, RD_VEC[i][5:0]);
      idle();
    end

    // R1 mirroring
    drive(16'h1FFF, 1, 0, 0); chk("R1 ram_addr top", ram_addr, 11'h7FF); idle();
    drive(16'h0800, 0, 1, 8'h5A);
    chk("R1 ram_addr alias", ram_addr, 0); chk("R1 ram_cs write", ram_cs, 1);
    chk("R7 fwd_wdata", fwd_wdata, 8'h5A); idle();

    // R2 index and ignored status write
    drive(16'h3FFD, 1, 0, 0); chk("R2 vid_reg mirror", vid_reg, 5); idle();
    drive(16'h2002, 0, 1, 8'hFF); chk("R2 status write no select", sel, 0); idle();
    drive(16'h200A, 0, 1, 8'hFF); chk("R2 status mirror write no select", sel, 0); idle();
    drive(16'h2005, 0, 1, 8'h11); chk("R2 write select", vid_cs, 1); idle();

    // R6 absent port
    pad_present = 2'b01;
    drive(16'h4017, 1, 0, 0);
    chk("R6 absent rdata", bus_rdata, 0); chk("R6 absent strobe", pad_rd, 0); idle();
    pad_present = 2'b11;

    // R7 writes
    drive(16'h4016, 0, 1, 8'h01);
    chk("R7 pad_wr", pad_wr, 1); chk("R7 pad write no apu", apu_cs, 0); idle();
    drive(16'h4014, 0, 1, 8'h02); chk("R7 dma_start", dma_start, 1); idle();
    drive(16'h4017, 0, 1, 8'h40);
    chk("R7 frame apu_cs", apu_cs, 1); chk("R7 frame apu_reg", apu_reg, 5'h17); idle();
    drive(16'h4013, 0, 1, 8'h40);
    chk("R7 apu_cs last", apu_cs, 1); chk("R7 apu_reg last", apu_reg, 5'h13); idle();

    // R8 ignored writes
    drive(16'h4018, 0, 1, 8'h33); chk("R8 gap write", {sel, pad_wr, dma_start}, 0); idle();
    drive(16'h5000, 0, 1, 8'h33); chk("R8 hole write", {sel, pad_wr, dma_start}, 0); idle();

    // R4 status read race window
    vid_dot = 9'd2;
    drive(16'h2002, 1, 0, 0); idle();
    chk("R4 dot2 suppress", nmi_suppress, 1);
    @(negedge clk); #1; chk("R4 one cycle", nmi_suppress, 0);
    vid_dot = 9'd3;
    drive(16'h3FFA, 1, 0, 0); idle(); chk("R4 dot3 mirror suppress", nmi_suppress, 1);
    vid_dot = 9'd4;
    drive(16'h2002, 1, 0, 0); idle(); chk("R4 dot4 none", nmi_suppress, 0);
    vid_dot = 9'd2;
    drive(16'h2004, 1, 0, 0); idle(); chk("R4 other index none", nmi_suppress, 0);
    vid_dot = 9'd100;

    // R11 enable edge
    vid_vblank = 1;
    drive(16'h2000, 0, 1, 8'h80); idle(); chk("R11 rise in vblank", nmi_delayed, 1);
    @(negedge clk); #1; chk("R11 one cycle", nmi_delayed, 0);
    drive(16'h2008, 0, 1, 8'h80); idle(); chk("R11 already on", nmi_delayed, 0);
    drive(16'h2000, 0, 1, 8'h00); idle(); chk("R10 clear no late", nmi_suppress, 0);
    vid_vblank = 0;
    drive(16'h2000, 0, 1, 8'h80); idle(); chk("R11 rise outside vblank", nmi_delayed, 0);

    // R10 clear with late flag, then R11 rises again
    late_flag = 1;
    drive(16'h2000, 0, 1, 8'h00); idle(); chk("R10 clear with late", nmi_suppress, 1);
    late_flag = 0; vid_vblank = 1;
    drive(16'h2000, 0, 1, 8'h80); idle(); chk("R11 rise after clear", nmi_delayed, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule